// File: doc/BRIEF.md
# Strided Interleave DMA Address Generator

This block produces the address stream for a DMA transfer, counted in quadwords, between a local scratchpad and main memory. In interleave mode the transfer is cut into chunks. The scratchpad side is read or written contiguously. The memory side steps over a programmable gap after each chunk. As a result, rows of a strided structure in memory are packed into, or unpacked from, a dense region of the scratchpad.

Software sets up the transfer with one start pulse. The pulse carries:
- the total quadword count,
- the chunk size,
- the skip size,
- the two start addresses,
- the direction.

The block then offers one request beat per quadword. Each beat carries both addresses and a direction flag, and the beat advances only when the consumer accepts it. When the count reaches zero the block raises a one-cycle completion pulse and sets a sticky interrupt flag.

Top module: `ilv_dma_agen`

## Requirements
- R1: Both beat addresses are quadword aligned. The low 4 bits of the programmed start addresses are dropped, and the low 4 bits of `req_maddr` and `req_saddr` always read zero.
- R2: `req_saddr` of beat i equals the aligned scratchpad start plus 16·i, modulo 2^SADDR_W. It never skips.
- R3: Beat i lies in chunk k = i / C at position p = i mod C, where C is the effective chunk size. Its `req_maddr` is the aligned memory start plus 16·(k·(C+S)+p), where S is the skip size.
- R4: Each chunk moves the smaller of the chunk size and the quadwords still remaining, so a final chunk shorter than the chunk size ends the transfer.
- R5: A chunk size of zero is treated as the full count, so the whole transfer runs as one contiguous chunk.
- R6: A beat is accepted only in a cycle where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the addresses and `rem_qwc` hold.
- R7: In the cycle after the last beat is accepted:
  - `done` is high for exactly one cycle,
  - `busy` is low,
  - `rem_qwc` reads zero.
- R8: `irq` is set together with `done`. It stays set until `irq_clr` is high, and a new set in the same cycle wins over the clear.
- R9: A start pulse while `busy` is high is ignored. The running transfer keeps its count, addresses and chunk layout.
- R10: `dir_in` is latched at start. A value of 0 gives `req_write_mem`=1 (scratchpad to memory) and a value of 1 gives `req_write_mem`=0 (memory to scratchpad). The flag holds for the whole transfer.
- R11: A start with a count of zero issues no beat and gives `done` and `irq` in the following cycle.
- R12: After reset:
  - `busy`, `req_valid`, `done` and `irq` are low,
  - `rem_qwc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Loads the configuration when idle |
| dir_in | input | 1 | 0: scratchpad to memory, 1: memory to scratchpad |
| cfg_qwc | input | CNT_W | Total quadword count |
| cfg_chunk | input | CNT_W | Chunk size in quadwords (0 = whole count) |
| cfg_skip | input | CNT_W | Memory gap after each chunk, in quadwords |
| cfg_maddr | input | ADDR_W | Memory start byte address |
| cfg_saddr | input | SADDR_W | Scratchpad start byte address |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| req_valid | output | 1 | Beat request valid |
| req_ready | input | 1 | Consumer accepts the current beat |
| req_write_mem | output | 1 | 1 when the beat writes memory |
| req_maddr | output | ADDR_W | Memory address of the beat |
| req_saddr | output | SADDR_W | Scratchpad address of the beat |
| busy | output | 1 | Transfer in progress |
| rem_qwc | output | CNT_W | Quadwords not yet accepted |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Sticky completion flag |

## Verification
Directed transfers separate the distinct chunk layouts:
- the count an exact multiple of the chunk size;
- the count leaving a short final chunk;
- a chunk larger than the count;
- a chunk size of zero;
- a chunk of one with zero skip, which must look like a plain linear copy.

Counts of zero and one isolate the completion timing from the address stepping. Unaligned start addresses show that the low bits are dropped. A second start injected mid-transfer shows that the running transfer is unaffected. Random transfers, with random throttling on `req_ready`, exercise the hold behaviour on stalled beats and the gap jumps landing on stalled cycles. Every accepted address is compared with a closed-form position formula rather than a step-by-step model.

// File: rtl/ilv_dma_agen.sv
module ilv_dma_agen #(
  parameter int ADDR_W  = 32,
  parameter int SADDR_W = 14,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               dir_in,
  input  logic [CNT_W-1:0]   cfg_qwc,
  input  logic [CNT_W-1:0]   cfg_chunk,
  input  logic [CNT_W-1:0]   cfg_skip,
  input  logic [ADDR_W-1:0]  cfg_maddr,
  input  logic [SADDR_W-1:0] cfg_saddr,
  input  logic               irq_clr,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_write_mem,
  output logic [ADDR_W-1:0]  req_maddr,
  output logic [SADDR_W-1:0] req_saddr,
  output logic               busy,
  output logic [CNT_W-1:0]   rem_qwc,
  output logic               done,
  output logic               irq
);
  localparam int QW_LSB = 4;

  logic               busy_q, dir_q, done_q, irq_q;
  logic [CNT_W-1:0]   rem_q, clen_q, cleft_q, skip_q;
  logic [ADDR_W-1:0]  maddr_q;
  logic [SADDR_W-1:0] saddr_q;

  wire accept    = busy_q & req_ready;
  wire last      = (rem_q == CNT_W'(1));
  wire chunk_end = (cleft_q == CNT_W'(1));
  wire launch    = start & ~busy_q;
  wire empty     = (cfg_qwc == '0);
  wire finish    = (launch & empty) | (accept & last);

  wire [CNT_W-1:0]  rem_nx    = rem_q - CNT_W'(1);
  wire [CNT_W-1:0]  next_len  = (rem_nx < clen_q) ? rem_nx : clen_q;
  wire [CNT_W-1:0]  eff_chunk = (cfg_chunk == '0) ? cfg_qwc : cfg_chunk;
  wire [ADDR_W-1:0] gap_step  = (ADDR_W'(skip_q) + ADDR_W'(1)) << QW_LSB;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      rem_q   <= '0;
      clen_q  <= '0;
      cleft_q <= '0;
      skip_q  <= '0;
      maddr_q <= '0;
      saddr_q <= '0;
    end else begin
      done_q <= finish;
      if (launch) begin
        dir_q   <= dir_in;
        rem_q   <= cfg_qwc;
        clen_q  <= eff_chunk;
        cleft_q <= (eff_chunk < cfg_qwc) ? eff_chunk : cfg_qwc;
        skip_q  <= cfg_skip;
        maddr_q <= {cfg_maddr[ADDR_W-1:QW_LSB], {QW_LSB{1'b0}}};
        saddr_q <= {cfg_saddr[SADDR_W-1:QW_LSB], {QW_LSB{1'b0}}};
        busy_q  <= ~empty;
      end else if (accept) begin
        rem_q   <= rem_nx;
        saddr_q <= saddr_q + SADDR_W'(16);
        if (chunk_end) begin
          maddr_q <= maddr_q + gap_step;
          cleft_q <= next_len;
        end else begin
          maddr_q <= maddr_q + ADDR_W'(16);
          cleft_q <= cleft_q - CNT_W'(1);
        end
        if (last) busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= finish | (irq_q & ~irq_clr);
  end

  assign req_valid     = busy_q;
  assign req_write_mem = ~dir_q;
  assign req_maddr     = maddr_q;
  assign req_saddr     = saddr_q;
  assign busy          = busy_q;
  assign rem_qwc       = rem_q;
  assign done          = done_q;
  assign irq           = irq_q;
endmodule

// File: rtl/ilv_dma_agen_chk.sv
module ilv_dma_agen_chk #(
  parameter int ADDR_W  = 32,
  parameter int SADDR_W = 14,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               irq_clr,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write_mem,
  input logic [ADDR_W-1:0]  req_maddr,
  input logic [SADDR_W-1:0] req_saddr,
  input logic               busy,
  input logic [CNT_W-1:0]   rem_qwc,
  input logic               done,
  input logic               irq
);
  // R1
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_maddr[3:0] == 4'h0 && req_saddr[3:0] == 4'h0));

  // R2
  saddr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && rem_qwc > CNT_W'(1)) |=>
      req_saddr == $past(req_saddr) + SADDR_W'(16));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_maddr) && $stable(req_saddr) && $stable(rem_qwc)));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && rem_qwc == '0));

  // R7
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R8
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> irq);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !req_ready) |=> ($stable(rem_qwc) && $stable(req_maddr)));

  // R10
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(req_write_mem));
endmodule

bind ilv_dma_agen ilv_dma_agen_chk #(
  .ADDR_W(ADDR_W), .SADDR_W(SADDR_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .irq_clr(irq_clr),
  .req_valid(req_valid), .req_ready(req_ready), .req_write_mem(req_write_mem),
  .req_maddr(req_maddr), .req_saddr(req_saddr), .busy(busy),
  .rem_qwc(rem_qwc), .done(done), .irq(irq)
);

// File: tb/ilv_dma_agen_tb.sv
module ilv_dma_agen_tb_top;
  localparam int ADDR_W  = 32;
  localparam int SADDR_W = 14;
  localparam int CNT_W   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir_in = 1'b0, irq_clr = 1'b0, req_ready = 1'b0;
  logic [CNT_W-1:0] cfg_qwc = '0, cfg_chunk = '0, cfg_skip = '0;
  logic [ADDR_W-1:0] cfg_maddr = '0;
  logic [SADDR_W-1:0] cfg_saddr = '0;
  logic req_valid, req_write_mem, busy, done, irq;
  logic [ADDR_W-1:0] req_maddr;
  logic [SADDR_W-1:0] req_saddr;
  logic [CNT_W-1:0] rem_qwc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ilv_dma_agen #(.ADDR_W(ADDR_W), .SADDR_W(SADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_in(dir_in),
    .cfg_qwc(cfg_qwc), .cfg_chunk(cfg_chunk), .cfg_skip(cfg_skip),
    .cfg_maddr(cfg_maddr), .cfg_saddr(cfg_saddr), .irq_clr(irq_clr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write_mem(req_write_mem),
    .req_maddr(req_maddr), .req_saddr(req_saddr), .busy(busy),
    .rem_qwc(rem_qwc), .done(done), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] exp_maddr(input logic [ADDR_W-1:0] base,
      input int ce, input int skip, input int i);
    int k = i / ce;
    int p = i % ce;
    return {base[ADDR_W-1:4], 4'h0} + ADDR_W'((k * (ce + skip) + p) * 16);
  endfunction

  function automatic logic [SADDR_W-1:0] exp_saddr(input logic [SADDR_W-1:0] base, input int i);
    return {base[SADDR_W-1:4], 4'h0} + SADDR_W'(i * 16);
  endfunction

  task automatic run_xfer(input int qwc, input int chunk, input int skip,
      input logic [ADDR_W-1:0] ma, input logic [SADDR_W-1:0] sa, input bit d,
      input int readyp, input bit inject, input string tag);
    int ce = (chunk == 0) ? qwc : chunk;
    int beats = 0;
    int guard = 0;
    bit m_bad = 0, s_bad = 0, h_bad = 0, v_bad = 0, dir_bad = 0;
    logic [ADDR_W-1:0] bad_m_act = '0, bad_m_exp = '0;
    logic [SADDR_W-1:0] bad_s_act = '0, bad_s_exp = '0;
    bit stalled = 0;
    logic [ADDR_W-1:0] hm = '0;
    logic [SADDR_W-1:0] hs = '0;
    @(negedge clk);
    cfg_qwc = CNT_W'(qwc); cfg_chunk = CNT_W'(chunk); cfg_skip = CNT_W'(skip);
    cfg_maddr = ma; cfg_saddr = sa; dir_in = d; start = 1'b1; req_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    cfg_qwc = CNT_W'($urandom); cfg_chunk = CNT_W'($urandom); cfg_skip = CNT_W'($urandom);
    cfg_maddr = $urandom; cfg_saddr = SADDR_W'($urandom); dir_in = ~d;
    if (qwc == 0) begin
      #1;
      check(done && !busy && !req_valid, {"R11 empty start ", tag}, {done, busy, req_valid}, 3'b100);
      check(irq, {"R11 irq on empty ", tag}, irq, 1);
      @(negedge clk);
      check(!done, {"R7 single pulse ", tag}, done, 0);
    end else begin
      #1;
      check(busy && rem_qwc == CNT_W'(qwc), {"R9 load ", tag}, rem_qwc, qwc);
      check(req_write_mem == !d, {"R10 direction ", tag}, req_write_mem, !d);
      while (beats < qwc && guard < 5000) begin
        guard++;
        req_ready = ($urandom_range(99) < readyp);
        if (inject && beats == 2) begin
          start = 1'b1; cfg_qwc = CNT_W'(3); cfg_chunk = CNT_W'(1); cfg_skip = CNT_W'(9);
          cfg_maddr = 32'h7000_0000;
        end else start = 1'b0;
        #1;
        if (!req_valid) v_bad = 1;
        if (req_write_mem != !d) dir_bad = 1;
        if (stalled && (req_maddr != hm || req_saddr != hs)) h_bad = 1;
        if (req_ready) begin
          if (req_maddr != exp_maddr(ma, ce, skip, beats) && !m_bad) begin
            m_bad = 1; bad_m_act = req_maddr; bad_m_exp = exp_maddr(ma, ce, skip, beats);
          end
          if (req_saddr != exp_saddr(sa, beats) && !s_bad) begin
            s_bad = 1; bad_s_act = req_saddr; bad_s_exp = exp_saddr(sa, beats);
          end
          beats++;
          stalled = 0;
        end else begin
          stalled = 1; hm = req_maddr; hs = req_saddr;
        end
        @(negedge clk);
      end
      req_ready = 1'b0; start = 1'b0;
      #1;
      check(!m_bad, {"R3 R4 R5 memory address ", tag}, bad_m_act, bad_m_exp);
      check(!s_bad, {"R2 scratch address ", tag}, bad_s_act, bad_s_exp);
      check(!v_bad && !h_bad, {"R6 valid/hold ", tag}, {v_bad, h_bad}, 0);
      check(!dir_bad, {"R10 direction held ", tag}, dir_bad, 0);
      if (inject) check(!m_bad && beats == qwc, {"R9 start ignored ", tag}, beats, qwc);
      check(done && !busy && rem_qwc == '0, {"R7 completion ", tag}, {done, busy, rem_qwc}, 18'h20000);
      check(irq, {"R8 irq set ", tag}, irq, 1);
      @(negedge clk);
      check(!done && !req_valid, {"R7 done one cycle ", tag}, {done, req_valid}, 0);
    end
    #1;
    check(irq, {"R8 irq sticky ", tag}, irq, 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    #1;
    check(!irq, {"R8 irq cleared ", tag}, irq, 0);
  endtask

  initial begin
    void'($urandom(32'd20250117));
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !req_valid && !done && !irq && rem_qwc == '0, "R12 reset state",
          {busy, req_valid, done, irq}, 0);
    rst_n = 1'b1;
    run_xfer(6, 2, 3, 32'h0000_1000, 14'h0100, 1'b0, 100, 1'b0, "even chunks");
    run_xfer(5, 2, 3, 32'h0000_2000, 14'h0200, 1'b0, 100, 1'b0, "short tail R4");
    run_xfer(3, 8, 4, 32'h0000_3000, 14'h0300, 1'b1, 100, 1'b0, "chunk over count");
    run_xfer(7, 0, 5, 32'h0000_4000, 14'h0400, 1'b1, 60, 1'b0, "zero chunk R5");
    run_xfer(4, 1, 0, 32'h0000_5000, 14'h0500, 1'b0, 70, 1'b0, "linear");
    run_xfer(1, 3, 2, 32'h0000_6000, 14'h0600, 1'b1, 100, 1'b0, "single beat");
    run_xfer(0, 3, 2, 32'h0000_7000, 14'h0700, 1'b0, 100, 1'b0, "empty");
    run_xfer(5, 2, 1, 32'h0000_800b, 14'h0807, 1'b0, 100, 1'b0, "unaligned R1");
    run_xfer(9, 3, 2, 32'h0000_9000, 14'h0900, 1'b1, 50, 1'b1, "busy start");
    run_xfer(4, 2, 2, 32'hffff_ffc0, 14'h3fe0, 1'b0, 80, 1'b0, "wrap");
    for (int n = 0; n < 25; n++) begin
      run_xfer($urandom_range(1, 40), $urandom_range(0, 9), $urandom_range(0, 12),
               $urandom, SADDR_W'($urandom), 1'($urandom), $urandom_range(30, 100),
               1'b0, "random");
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule